// File: doc/BRIEF.md
# Dual-Mode Serial Command Word Receiver

This block takes 16-bit command words from a three-wire serial link: a serial clock, an active-low frame sync and a data line. All three are brought into the system clock domain through two-flop synchronizers, and edges are found on the synchronized copies. The system clock must run at least four times faster than the serial clock. Data is captured on each falling edge of the serial clock, most significant bit first.

A static mode input picks one of two framing disciplines. In strict mode the frame sync has to stay low across all sixteen bits, and the word is released only when the sync returns high. An early release throws the word away. In relaxed mode a brief low pulse on the sync only marks the start of a frame, and the word is released as soon as its sixteenth bit arrives. Each released word appears on a registered bus together with a one-cycle strobe.

For cascading several receivers on one link, a second output repeats the data stream sixteen serial clocks late. An enable input gates this output, and it is forced low while the enable is off.

Top module: `serial_cmd_rx`

## Requirements
- R1: Words are assembled from 16 bits sampled on falling serial clock edges, the first sampled bit becoming bit 15 of `word_o` and the last bit 0.
- R2: With `strict_mode_i` high, a word with all 16 bits received while the sync was low is released (new `word_o`, `word_valid_o` pulse) only after the frame sync rises.
- R3: With `strict_mode_i` high, a frame sync rise before the 16th falling edge discards the partial word: no `word_valid_o` pulse occurs and `word_o` keeps its previous value.
- R4: With `strict_mode_i` low, a frame starts at a sync falling edge, the sync may return high at any point, and the word is released right after the 16th falling edge without waiting for the sync.
- R5: With `strict_mode_i` low, falling edges after the 16th and before the next sync falling edge produce no further release and leave `word_o` unchanged.
- R6: A sync falling edge always restarts the bit count, so bits of an unfinished frame never reach a later word.
- R7: With `chain_en_i` high, after the k-th falling serial clock edge (k counted from reset, k ≥ 16) `chain_dout_o` equals the bit sampled at edge k−16, and it reads 0 for the first 16 edges after reset.
- R8: With `chain_en_i` low, `chain_dout_o` is held at 0.
- R9: While `rst` is high and right after it, `word_o` is 0, `word_valid_o` is 0 and `chain_dout_o` is 0.
- R10: `word_valid_o` is high for exactly one system clock cycle per released word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strict_mode_i | input | 1 | Static framing select: 1 strict, 0 relaxed |
| ser_clk_i | input | 1 | Serial clock, asynchronous to clk |
| ser_fs_i | input | 1 | Frame sync, active low |
| ser_din_i | input | 1 | Serial data |
| chain_en_i | input | 1 | Enables the cascaded data output |
| word_o | output | 16 | Last released command word |
| word_valid_o | output | 1 | One-cycle strobe when `word_o` is updated |
| chain_dout_o | output | 1 | Data stream delayed by 16 serial clocks |

## Verification
A wrong bit counter shows up at the ports within one frame as a missing, extra or early `word_valid_o` pulse, or as a word shifted by one bit position. Broken discard or restart logic shows a stale word after an aborted or restarted frame, usually within one serial bit time of the frame's end. A delay line that is one stage too short or too long is exposed by `chain_dout_o` on the very first bit of the second frame, because consecutive frames carry different patterns.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  // Edge and level events of the serial link in the system clock domain
  typedef struct packed {
    logic clk_fall;  // falling edge of the serial clock
    logic fs_fall;   // frame sync went low
    logic fs_rise;   // frame sync went high
    logic fs_lvl;    // synchronized frame sync level
    logic din;       // synchronized data bit
  } ser_evt_t;

  localparam int unsigned SER_LINES = 3;  // clock, sync, data

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/ser_edge.sv
module ser_edge
  import serial_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     ser_clk_i,
  input  logic     ser_fs_i,
  input  logic     ser_din_i,
  output ser_evt_t evt_o
);

  // Idle line: clock high, sync high, data low
  localparam logic [SER_LINES-1:0] IDLE = 3'b110;

  logic [SER_LINES-1:0] lines_s;
  logic                 clk_prev_q;
  logic                 fs_prev_q;

  bit_sync #(
    .WIDTH   (SER_LINES),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (IDLE)
  ) i_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({ser_clk_i, ser_fs_i, ser_din_i}),
    .sync_o  (lines_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_prev_q <= 1'b1;
      fs_prev_q  <= 1'b1;
    end else begin
      clk_prev_q <= lines_s[2];
      fs_prev_q  <= lines_s[1];
    end
  end

  always_comb begin
    evt_o.clk_fall = clk_prev_q & ~lines_s[2];
    evt_o.fs_fall  = fs_prev_q  & ~lines_s[1];
    evt_o.fs_rise  = ~fs_prev_q &  lines_s[1];
    evt_o.fs_lvl   = lines_s[1];
    evt_o.din      = lines_s[0];
  end

endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import serial_rx_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strict_i,
  input  ser_evt_t          evt_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic [CNT_W-1:0]  cnt_o
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shift_q;
  logic [WORD_W-1:0] word_q;
  logic              valid_q;
  logic [WORD_W-1:0] shift_nxt;

  assign shift_nxt = {shift_q[WORD_W-2:0], evt_i.din};

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      shift_q  <= '0;
      word_q   <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (evt_i.fs_fall) begin
        // a new frame always wins over any unfinished one
        active_q <= 1'b1;
        cnt_q    <= '0;
      end else if (strict_i) begin
        if (evt_i.fs_rise) begin
          active_q <= 1'b0;
          cnt_q    <= '0;
          if (active_q && cnt_q == FULL) begin
            word_q  <= shift_q;
            valid_q <= 1'b1;
          end
        end else if (active_q && evt_i.clk_fall && !evt_i.fs_lvl && cnt_q < FULL) begin
          shift_q <= shift_nxt;
          cnt_q   <= cnt_q + 1'b1;
        end
      end else begin
        if (active_q && evt_i.clk_fall && cnt_q < FULL) begin
          shift_q <= shift_nxt;
          cnt_q   <= cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            word_q   <= shift_nxt;
            valid_q  <= 1'b1;
            active_q <= 1'b0;
          end
        end
      end
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
  assign cnt_o   = cnt_q;

endmodule

// File: rtl/chain_delay.sv
module chain_delay #(
  parameter int unsigned DEPTH = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic shift_i,
  input  logic bit_i,
  input  logic en_i,
  output logic dout_o
);

  logic [DEPTH-1:0] line_q;
  logic             tap_q;
  logic             dout_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      tap_q  <= 1'b0;
    end else if (shift_i) begin
      // tap takes the oldest bit before it is shifted out: DEPTH edges late
      tap_q  <= line_q[DEPTH-1];
      line_q <= {line_q[DEPTH-2:0], bit_i};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dout_q <= 1'b0;
    else     dout_q <= en_i & tap_q;
  end

  assign dout_o = dout_q;

endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
  import serial_rx_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strict_mode_i,
  input  logic              ser_clk_i,
  input  logic              ser_fs_i,
  input  logic              ser_din_i,
  input  logic              chain_en_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              chain_dout_o
);

  ser_evt_t         evt;
  logic [CNT_W-1:0] bit_cnt;

  ser_edge #(
    .SYNC_STAGES (SYNC_STAGES)
  ) i_edge (
    .clk       (clk),
    .rst       (rst),
    .ser_clk_i (ser_clk_i),
    .ser_fs_i  (ser_fs_i),
    .ser_din_i (ser_din_i),
    .evt_o     (evt)
  );

  frame_ctrl #(
    .WORD_W (WORD_W)
  ) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .strict_i (strict_mode_i),
    .evt_i    (evt),
    .word_o   (word_o),
    .valid_o  (word_valid_o),
    .cnt_o    (bit_cnt)
  );

  chain_delay #(
    .DEPTH (WORD_W)
  ) i_chain (
    .clk     (clk),
    .rst     (rst),
    .shift_i (evt.clk_fall),
    .bit_i   (evt.din),
    .en_i    (chain_en_i),
    .dout_o  (chain_dout_o)
  );

endmodule

// File: rtl/serial_cmd_rx_chk.sv
module serial_cmd_rx_chk
  import serial_rx_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CNT_W = $clog2(WORD_W + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             strict_mode_i,
  input logic             chain_en_i,
  input logic             word_valid_o,
  input logic             chain_dout_o,
  input ser_evt_t         evt,
  input logic [CNT_W-1:0] bit_cnt
);

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(WORD_W)); // R1

  AST_STRICT_COMMIT_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    (strict_mode_i && word_valid_o) |-> $past(evt.fs_rise)); // R2

  AST_RELAXED_COMMIT_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    (!strict_mode_i && word_valid_o) |-> $past(evt.clk_fall)); // R4

  AST_FS_FALL_RESTART: assert property (@(posedge clk) disable iff (rst)
    evt.fs_fall |=> (bit_cnt == '0)); // R6

  AST_CHAIN_GATED: assert property (@(posedge clk) disable iff (rst)
    !chain_en_i |=> !chain_dout_o); // R8

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    word_valid_o |=> !word_valid_o); // R10

endmodule

bind serial_cmd_rx serial_cmd_rx_chk #(
  .WORD_W (WORD_W)
) i_chk (
  .clk           (clk),
  .rst           (rst),
  .strict_mode_i (strict_mode_i),
  .chain_en_i    (chain_en_i),
  .word_valid_o  (word_valid_o),
  .chain_dout_o  (chain_dout_o),
  .evt           (evt),
  .bit_cnt       (bit_cnt)
);

// File: tb/test_serial_cmd_rx.sv
module test_serial_cmd_rx;

  localparam time CLK_PERIOD = 10ns;
  localparam int  HALF_BIT   = 4;     // system cycles per serial clock phase
  localparam int  NVEC       = 6;

  // {strict, early_release, exp_valid, nbits[4:0], word[15:0], exp_word[15:0]}
  localparam logic [39:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 1'b1, 5'd16, 16'hA5C3, 16'hA5C3},  // R2 R1
    {1'b1, 1'b0, 1'b1, 5'd16, 16'h0001, 16'h0001},  // R2 R1 lsb
    {1'b1, 1'b0, 1'b0, 5'd10, 16'hFFFF, 16'h0001},  // R3 short frame
    {1'b0, 1'b1, 1'b1, 5'd16, 16'h8002, 16'h8002},  // R4 early sync release
    {1'b0, 1'b0, 1'b1, 5'd16, 16'h7FFE, 16'h7FFE},  // R4
    {1'b1, 1'b0, 1'b1, 5'd16, 16'h1234, 16'h1234}   // R2
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strict_mode_i = 1'b1;
  logic        ser_clk_i = 1'b1;
  logic        ser_fs_i = 1'b1;
  logic        ser_din_i = 1'b0;
  logic        chain_en_i = 1'b1;
  logic [15:0] word_o;
  logic        word_valid_o;
  logic        chain_dout_o;

  int errors = 0;
  int checks = 0;
  int vcnt = 0;
  int double_cnt = 0;
  int nfall = 0;
  logic prev_v = 1'b0;
  logic hist [0:1023];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_cmd_rx i_serial_cmd_rx (
    .clk           (clk),
    .rst           (rst),
    .strict_mode_i (strict_mode_i),
    .ser_clk_i     (ser_clk_i),
    .ser_fs_i      (ser_fs_i),
    .ser_din_i     (ser_din_i),
    .chain_en_i    (chain_en_i),
    .word_o        (word_o),
    .word_valid_o  (word_valid_o),
    .chain_dout_o  (chain_dout_o)
  );

  always @(negedge clk) begin
    if (word_valid_o) vcnt++;
    if (prev_v && word_valid_o) double_cnt++;
    prev_v <= word_valid_o;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // one serial bit: data set while clock high, falling edge, dout checked in high phase
  task automatic send_bit(input logic b);
    int  k;
    logic exp;
    k = nfall;
    ser_din_i = b;
    hist[k] = b;
    wait_cyc(HALF_BIT);
    ser_clk_i = 1'b0;
    nfall++;
    wait_cyc(HALF_BIT);
    ser_clk_i = 1'b1;
    wait_cyc(HALF_BIT - 1);
    exp = (k >= 16) ? hist[k-16] : 1'b0;
    if (chain_en_i) check("R7 chain_dout", 32'(chain_dout_o), 32'(exp));
    else            check("R8 chain_dout gated", 32'(chain_dout_o), 32'(1'b0));
    wait_cyc(1);
  endtask

  task automatic send_frame(input logic strict, input logic early,
                            input int nbits, input logic [15:0] w);
    strict_mode_i = strict;
    ser_fs_i = 1'b0;
    wait_cyc(HALF_BIT);
    for (int i = 0; i < nbits; i++) begin
      send_bit(w[15-i]);
      if (early && i == 1) ser_fs_i = 1'b1;
    end
    wait_cyc(HALF_BIT);
    ser_fs_i = 1'b1;
    wait_cyc(12);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int v0;
    for (int i = 0; i < 1024; i++) hist[i] = 1'b0;
    wait_cyc(5);
    // R9 reset state
    check("R9 word_o in reset", 32'(word_o), 32'h0);
    check("R9 valid in reset", 32'(word_valid_o), 32'h0);
    check("R9 dout in reset", 32'(chain_dout_o), 32'h0);
    rst = 1'b0;
    wait_cyc(4);
    check("R9 word_o after reset", 32'(word_o), 32'h0);

    // table walk: R1 R2 R3 R4
    for (int n = 0; n < NVEC; n++) begin
      v0 = vcnt;
      send_frame(VEC[n][39], VEC[n][38], int'(VEC[n][36:32]), VEC[n][31:16]);
      check($sformatf("R2/R3/R4 vec%0d valid count", n), 32'(vcnt - v0), 32'(VEC[n][37]));
      check($sformatf("R1 vec%0d word", n), 32'(word_o), 32'(VEC[n][15:0]));
    end

    // R2: strict word not released before the sync rises
    strict_mode_i = 1'b1;
    v0 = vcnt;
    ser_fs_i = 1'b0;
    wait_cyc(HALF_BIT);
    for (int i = 0; i < 16; i++) send_bit(1'(16'hC33C >> (15 - i)));
    wait_cyc(12);
    check("R2 no release while sync low", 32'(vcnt - v0), 32'd0);
    check("R2 word held while sync low", 32'(word_o), 32'h1234);
    ser_fs_i = 1'b1;
    wait_cyc(12);
    check("R2 release on sync rise", 32'(vcnt - v0), 32'd1);
    check("R2 word after rise", 32'(word_o), 32'hC33C);

    // R5: extra edges after the 16th in relaxed mode
    v0 = vcnt;
    send_frame(1'b0, 1'b0, 16, 16'h5A5A);
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    wait_cyc(12);
    check("R5 single release", 32'(vcnt - v0), 32'd1);
    check("R5 word unchanged", 32'(word_o), 32'h5A5A);

    // R6: unfinished relaxed frame restarted by a new sync fall
    v0 = vcnt;
    strict_mode_i = 1'b0;
    ser_fs_i = 1'b0;
    wait_cyc(HALF_BIT);
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    ser_fs_i = 1'b1;
    wait_cyc(HALF_BIT);
    send_frame(1'b0, 1'b0, 16, 16'h0F0F);
    check("R6 restart release count", 32'(vcnt - v0), 32'd1);
    check("R6 restart word", 32'(word_o), 32'h0F0F);

    // R8: chain output gated off, then back on (R7 continues)
    chain_en_i = 1'b0;
    wait_cyc(2);
    send_frame(1'b0, 1'b0, 16, 16'hFFFF);
    check("R8 word still received", 32'(word_o), 32'hFFFF);
    chain_en_i = 1'b1;
    wait_cyc(2);
    send_frame(1'b1, 1'b0, 16, 16'h6C93);
    check("R1 word after gating", 32'(word_o), 32'h6C93);

    // R10
    check("R10 valid single cycle", 32'(double_cnt), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule